// File: doc/BRIEF.md
# Serial Transmitter with Line-Break Generator

This block serialises bytes onto an asynchronous serial line. Characters are written into a small internal queue. A bit-time strobe from an external baud generator paces them onto the line. Each character goes out as a start bit, eight data bits sent least significant first, and a stop bit. When nothing is being sent, the line rests at the marking level (high).

An enable level controls whether new characters and break requests are accepted. Two status outputs report the block's condition. The ready flag means the queue can take another character. The empty flag means the transmitter is enabled and holds no work at all. Turning the enable off clears both flags at once. Everything already queued is still sent to completion.

Two command pulses start and stop a break, which holds the line at spacing (low). Two further pulses ask for a flow-control character to be sent. These flow characters (resume and pause) come from two programmable byte inputs.

The controller is a state machine with six states:
- IDLE: the line is marking.
- START: the start bit is on the line.
- DATA: the eight data bits are shifted out.
- STOP: the stop bit is on the line.
- BREAK: the line is held low.
- MARK: a one-bit marking guard that follows every break.

All transitions happen on a bit strobe:
- IDLE, STOP and MARK each launch work in the order flow character, then queued character, then pending break. With nothing to do, they fall to IDLE.
- START advances to DATA.
- DATA loops on itself until the eighth bit has been sent, then moves to STOP.
- BREAK moves to MARK once the break request has been withdrawn.

Top module: `uart_brk_tx`

## Requirements
- R1: `tx_rdy` equals `tx_en` AND (queue not full), with a default queue depth of 4. It is combinational, so raising `tx_en` asserts it and lowering `tx_en` drops it in the same cycle.
- R2: `tx_emt` is high only when all of these hold: `tx_en` is high, the queue is empty, no flow character is pending, and the state machine is IDLE. It is never high while `tx_en` is low.
- R3: Each character is sent as one start bit at 0, then the eight data bits least significant first, then one stop bit at 1. Each bit lasts exactly one strobe period. Queued characters follow one another with no extra idle bits between them.
- R4: A push is accepted only while `tx_rdy` is high. Pushes made while disabled or while the queue is full are dropped. Every accepted character is sent, even if `tx_en` is lowered afterwards.
- R5: A start-break pulse is ignored while `tx_en` is low. An accepted break begins only after every queued character has been sent. This includes characters pushed after the request.
- R6: If the transmitter is empty when a break is accepted, `txd` goes low within two bit periods. It stays low until the break is stopped.
- R7: After a stop-break pulse, `txd` returns high within two bit periods. It then stays high for at least one full bit period before any following start bit.
- R8: A resume or pause request sends `xon_char` or `xoff_char` respectively. The flow character goes ahead of any queued character that has not yet started. If both requests are outstanding, the later one wins. A pause wins when both arrive in the same cycle.
- R9: After reset, `txd` is 1. With `tx_en` low, `tx_rdy` and `tx_emt` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmitter enable level |
| push_valid | input | 1 | Write strobe for `push_data` |
| push_data | input | 8 | Character to queue |
| xon_req | input | 1 | Pulse: send resume character |
| xoff_req | input | 1 | Pulse: send pause character |
| xon_char | input | 8 | Resume character value |
| xoff_char | input | 8 | Pause character value |
| brk_start | input | 1 | Pulse: begin a line break |
| brk_stop | input | 1 | Pulse: end a line break |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| txd | output | 1 | Serial line, idles high |
| tx_rdy | output | 1 | Queue can accept a character |
| tx_emt | output | 1 | Enabled and fully drained |

## Verification
The bench decodes the line itself. It targets these corner cases:
- A disable with three characters queued. A design that stopped at once would lose the tail of the queue.
- A break requested behind queued characters, with one more character pushed after the request. A design that broke early would show a framing error before all three bytes arrive.
- The guard bit after a break. A design that skipped it would start the next frame with no marking gap.
- Flow requests raised in mid-frame, including two requests back to back and two in the same cycle. A design with the wrong priority would send the wrong flow byte, or send it after the queued byte.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP,
        TX_BREAK,
        TX_MARK
    } tx_state_e;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CFULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_p, wr_p;
    logic [CW-1:0] cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == CFULL);
    assign dout  = mem[rd_p];

    always_ff @(posedge clk) begin
        if (push) mem[wr_p] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_p <= '0;
            wr_p <= '0;
            cnt  <= '0;
        end else begin
            if (push) wr_p <= (wr_p == LAST) ? '0 : wr_p + 1'b1;
            if (pop)  rd_p <= (rd_p == LAST) ? '0 : rd_p + 1'b1;
            unique case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R4
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R4
    fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/tx_flow_req.sv
module tx_flow_req (
    input  logic clk,
    input  logic rst_n,
    input  logic on_req,
    input  logic off_req,
    input  logic take,
    output logic pend,
    output logic sel_off
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            sel_off <= 1'b0;
        end else begin
            if (on_req || off_req) pend <= 1'b1;
            else if (take)         pend <= 1'b0;
            if (off_req)     sel_off <= 1'b1;
            else if (on_req) sel_off <= 1'b0;
        end
    end

    // R8
    flow_take_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> pend);
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
    import uart_brk_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic          push_valid,
    input  logic [DW-1:0] push_data,
    input  logic          xon_req,
    input  logic          xoff_req,
    input  logic [DW-1:0] xon_char,
    input  logic [DW-1:0] xoff_char,
    input  logic          brk_start,
    input  logic          brk_stop,
    input  logic          bit_tick,
    output logic          txd,
    output logic          tx_rdy,
    output logic          tx_emt
);
    localparam int BW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [BW-1:0] BLAST = BW'(DW - 1);

    tx_state_e     st, st_nx;
    logic [DW-1:0] sh, sh_nx;
    logic [BW-1:0] bidx, bidx_nx;
    logic          brk_pend;
    logic          q_empty, q_full, q_pop, q_push;
    logic [DW-1:0] q_dout;
    logic          fl_pend, fl_off, fl_take;
    logic          do_launch;

    assign q_push = push_valid && tx_rdy;

    txq_fifo #(.W(DW), .DEPTH(DEPTH)) u_q (
        .clk(clk), .rst_n(rst_n), .push(q_push), .din(push_data),
        .pop(q_pop), .dout(q_dout), .empty(q_empty), .full(q_full)
    );

    tx_flow_req u_flow (
        .clk(clk), .rst_n(rst_n), .on_req(xon_req), .off_req(xoff_req),
        .take(fl_take), .pend(fl_pend), .sel_off(fl_off)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  brk_pend <= 1'b0;
        else if (brk_stop)           brk_pend <= 1'b0;
        else if (brk_start && tx_en) brk_pend <= 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= TX_IDLE;
            sh   <= '0;
            bidx <= '0;
        end else begin
            st   <= st_nx;
            sh   <= sh_nx;
            bidx <= bidx_nx;
        end
    end

    // next-state logic
    always_comb begin
        st_nx     = st;
        sh_nx     = sh;
        bidx_nx   = bidx;
        q_pop     = 1'b0;
        fl_take   = 1'b0;
        do_launch = 1'b0;
        unique case (st)
            TX_IDLE, TX_STOP, TX_MARK: do_launch = bit_tick;
            TX_START: if (bit_tick) begin
                st_nx   = TX_DATA;
                bidx_nx = '0;
            end
            TX_DATA: if (bit_tick) begin
                sh_nx = sh >> 1;
                if (bidx == BLAST) st_nx = TX_STOP;
                else bidx_nx = bidx + 1'b1;
            end
            TX_BREAK: if (bit_tick && !brk_pend) st_nx = TX_MARK;
            default: st_nx = TX_IDLE;
        endcase
        if (do_launch) begin
            if (fl_pend) begin
                st_nx   = TX_START;
                sh_nx   = fl_off ? xoff_char : xon_char;
                fl_take = 1'b1;
            end else if (!q_empty) begin
                st_nx = TX_START;
                sh_nx = q_dout;
                q_pop = 1'b1;
            end else if (brk_pend && tx_en) begin
                st_nx = TX_BREAK;
            end else begin
                st_nx = TX_IDLE;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (st)
            TX_START, TX_BREAK: txd = 1'b0;
            TX_DATA:            txd = sh[0];
            default:            txd = 1'b1;
        endcase
        tx_rdy = tx_en && !q_full;
        tx_emt = tx_en && q_empty && !fl_pend && (st == TX_IDLE);
    end

    // R1
    rdy_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rdy |-> tx_en);
    // R2
    emt_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_emt |-> txd);
    // R3
    frame_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_START && $past(st) != TX_START) |-> $past(bit_tick));
    // R5
    brk_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_BREAK && $past(st) != TX_BREAK) |-> ($past(q_empty) && !$past(fl_pend)));
    // R7
    brk_exit_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == TX_BREAK && st != TX_BREAK) |-> st == TX_MARK);
endmodule

// File: tb/uart_brk_tx_test.sv
`timescale 1ns/1ps
module uart_brk_tx_test;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       tx_en = 1'b0, push_valid = 1'b0, xon_req = 1'b0, xoff_req = 1'b0;
    logic [7:0] push_data = '0, xon_char = 8'h5A, xoff_char = 8'hC3;
    logic       brk_start = 1'b0, brk_stop = 1'b0, bit_tick = 1'b0;
    logic       txd, tx_rdy, tx_emt;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$], rx_q[$];
    int brk_cnt = 0, gap = 0, ones_run = 0, dst = 0, dbn = 0;
    logic [7:0] dsh;

    uart_brk_tx uut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .push_valid(push_valid),
        .push_data(push_data), .xon_req(xon_req), .xoff_req(xoff_req),
        .xon_char(xon_char), .xoff_char(xoff_char), .brk_start(brk_start),
        .brk_stop(brk_stop), .bit_tick(bit_tick), .txd(txd), .tx_rdy(tx_rdy),
        .tx_emt(tx_emt)
    );

    initial forever #2.5 clk = ~clk;

    task automatic decode(input logic s);
        unique case (dst)
            0: if (!s) begin gap = ones_run; dst = 1; dbn = 0; end
            1: if (dbn < 8) begin dsh[dbn] = s; dbn++; end
               else if (s) begin rx_q.push_back(dsh); dst = 0; end
               else begin brk_cnt++; dst = 2; end
            default: if (s) dst = 0;
        endcase
        ones_run = s ? ones_run + 1 : 0;
    endtask

    // bit strobe every 4 clocks; line sampled just before each strobe edge
    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin tc = 0; bit_tick = 1'b0; end
            else begin
                tc = (tc + 1) % 4;
                if (tc == 0) begin decode(txd); bit_tick = 1'b1; end
                else bit_tick = 1'b0;
            end
        end
    end

    function automatic logic [7:0] flow_byte(input bit last_off);
        return last_off ? xoff_char : xon_char;
    endfunction

    task automatic step; @(negedge clk); #0.5; endtask
    task automatic steps(input int n); repeat (n) step(); endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input bit expect_ok);
        push_valid = 1'b1; push_data = b;
        if (expect_ok) exp_q.push_back(b);
        step();
        push_valid = 1'b0;
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1; step(); sig = 1'b0;
    endtask

    task automatic cmp_q(input string tag);
        chk(rx_q.size() == exp_q.size(), {tag, " count"}, rx_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < rx_q.size(); i++)
            chk(rx_q[i] == exp_q[i], {tag, " byte"}, rx_q[i], exp_q[i]);
        rx_q.delete(); exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        steps(3);
        // R9 reset state
        chk(txd == 1'b1, "R9 txd", txd, 1);
        chk(tx_rdy == 1'b0 && tx_emt == 1'b0, "R9 flags", {tx_rdy, tx_emt}, 0);
        rst_n = 1'b1; steps(2);
        tx_en = 1'b1; step();
        chk(tx_rdy == 1'b1, "R1 enable rdy", tx_rdy, 1);
        steps(2);
        chk(tx_emt == 1'b1, "R2 emt idle", tx_emt, 1);

        // R3 single frame
        push(8'hA5, 1); steps(60);
        cmp_q("R3 single");
        chk(brk_cnt == 0, "R3 framing", brk_cnt, 0);

        // R3 random back-to-back traffic
        for (int i = 0; i < 30; i++) begin
            while (!tx_rdy) step();
            push(8'($urandom), 1);
            steps($urandom % 8);
        end
        steps(30 * 44 + 100);
        cmp_q("R3 random");

        // R4 fill the queue, then one dropped push
        begin
            int n = 0;
            while (tx_rdy && n < 10) begin push(8'h40 + 8'(n), 1); n++; end
            chk(n >= 4 && n <= 5, "R1 depth", n, 4);
            push(8'hEE, 0);
        end
        steps(8 * 44);
        cmp_q("R4 full drop");

        // R4 / R1 / R2 drain on disable
        push(8'h81, 1); push(8'h82, 1); push(8'h83, 1);
        tx_en = 1'b0; step();
        chk(tx_rdy == 1'b0, "R1 disable rdy", tx_rdy, 0);
        chk(tx_emt == 1'b0, "R2 disable emt", tx_emt, 0);
        push(8'h77, 0);
        steps(4 * 44);
        cmp_q("R4 drain");
        chk(tx_emt == 1'b0, "R2 emt while off", tx_emt, 0);

        // R5 break ignored while disabled
        pulse(brk_start); steps(20);
        chk(txd == 1'b1 && brk_cnt == 0, "R5 disabled break", txd, 1);
        tx_en = 1'b1; steps(12);
        chk(txd == 1'b1, "R5 not latched", txd, 1);

        // R6 break from empty
        pulse(brk_start); steps(8);
        chk(txd == 1'b0, "R6 break within 2 bits", txd, 0);
        steps(40);
        chk(txd == 1'b0, "R6 break held", txd, 0);
        chk(tx_emt == 1'b0, "R2 emt in break", tx_emt, 0);

        // R7 stop break and guard bit
        pulse(brk_stop); steps(8);
        chk(txd == 1'b1, "R7 mark within 2 bits", txd, 1);
        push(8'h3C, 1); steps(60);
        cmp_q("R7 after break");
        chk(gap >= 1, "R7 guard bit", gap, 1);
        brk_cnt = 0;

        // R5 break behind queued data, incl. a later push
        push(8'h11, 1); push(8'h22, 1);
        pulse(brk_start); steps(3);
        push(8'h33, 1);
        begin
            int w = 0;
            while (brk_cnt == 0 && w < 400) begin step(); w++; end
        end
        chk(brk_cnt == 1, "R5 break seen", brk_cnt, 1);
        cmp_q("R5 data before break");
        pulse(brk_stop); steps(20);
        brk_cnt = 0;

        // R8 resume request mid-frame
        push(8'h01, 1); push(8'h02, 1); steps(12);
        pulse(xon_req);
        exp_q.insert(1, flow_byte(0));
        steps(3 * 44);
        cmp_q("R8 xon");

        // R8 later request wins
        push(8'h03, 1); push(8'h04, 1); steps(12);
        pulse(xon_req); pulse(xoff_req);
        exp_q.insert(1, flow_byte(1));
        steps(3 * 44);
        cmp_q("R8 latest");

        // R8 same-cycle requests: pause wins
        push(8'h05, 1); push(8'h06, 1); steps(12);
        xon_req = 1'b1; xoff_req = 1'b1; step(); xon_req = 1'b0; xoff_req = 1'b0;
        exp_q.insert(1, flow_byte(1));
        steps(3 * 44);
        cmp_q("R8 same cycle");
        chk(brk_cnt == 0, "R3 no framing", brk_cnt, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule